// File: doc/BRIEF.md
# Serial Display-RAM Slave Port

This block is the host-facing side of a segment display controller. A host drives a chip-select, a write strobe, a read strobe and a single data wire. The block samples all four inside its own faster system clock and splits the bit stream into transactions. Each transaction begins with a three-bit operation prefix. Depending on that prefix, the block then reads nibbles from the display store, writes nibbles into it, does a read-then-write on each location, or accepts 9-bit configuration words.

The block owns a 64-word by 4-bit display store. A second, independent read port lets the panel scanner fetch any word at any time. Word `2k` holds commons 0..3 of segment `k`, and word `2k+1` holds commons 4..7 of that segment, so the scanner can decode a location without help. Configuration words leave the block as a single-cycle strobe with the 9-bit code, and a downstream decoder interprets them.

The command output is a valid-only stream, with no ready and no back-pressure. Each valid cycle carries exactly one code, and the consumer must take it in that cycle. The serial pins are the only inbound path. The host paces them, and the block never stalls them.

Top module: `lcd_serial_port`

## Requirements
- R1: The first three write-strobe rising edges after chip-select falls carry the prefix, first bit first. `110` selects read, `101` selects write or read-modify-write, and `100` selects command mode. Any other prefix makes the block ignore every further edge until chip-select rises: no store write, no command strobe, line released.
- R2: In the data modes, the next six write-strobe rising edges carry the word address, most significant bit first. In write mode, the following four rising edges carry data bits D0, D1, D2, D3 in that order. The nibble is then stored at the address and is visible on the scan port.
- R3: After each completed nibble, whether read or written, the word address advances by one without a new address. Word 63 is followed by word 0.
- R4: In read mode, each read-strobe rising edge puts the next bit of the current word on `sdata_o`, in the order D0..D3, and the bit is held until the next read-strobe rise. Further rises continue from the following words.
- R5: In `101` mode, if a read-strobe rise arrives before any data bit of a nibble, the four read rises return the old nibble at the current address. The next four write rises then store the new nibble at that same address, and only then does the address advance. A nibble that starts with a write rise is a plain write.
- R6: In command mode, each group of nine write rises forms one code, C8 first. It leaves as a `cmd_valid_o` pulse exactly one cycle wide with the code on `cmd_code_o`, and unknown codes are passed out too. Later codes in the same chip-select window need no new prefix.
- R7: Chip-select going high aborts the transaction. A partly shifted nibble is not stored, and the mode is forgotten, so the next low window must start with a new prefix.
- R8: `sdata_oe_o` rises on the first read-strobe rise of a read phase. It falls on the next write-strobe rise or when chip-select goes high, and it is never high in write or command mode.
- R9: After reset, every store word reads 0, `sdata_oe_o` is 0 and `cmd_valid_o` is 0. The scan port returns any word combinationally, regardless of serial traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous to `clk` |
| wr_clk_i | input | 1 | Write strobe; bits captured on its rising edge |
| rd_clk_i | input | 1 | Read strobe; bits launched on its rising edge |
| sdata_i | input | 1 | Data wire as seen at the pad input |
| sdata_o | output | 1 | Data bit driven toward the pad |
| sdata_oe_o | output | 1 | Pad output enable |
| scan_addr_i | input | 6 | Scanner word address |
| scan_data_o | output | 4 | Scanner word data |
| cmd_valid_o | output | 1 | One-cycle configuration-code strobe |
| cmd_code_o | output | 9 | Configuration code |

## Verification
The embedded properties assume that the host keeps each strobe level and each data value steady for several system-clock periods. Under that assumption, no two rising edges of the same strobe can be detected in adjacent cycles, which makes a doubled command pulse impossible. They also assume that chip-select is high whenever the host changes transaction type. The directed stimulus holds every serial level for six system cycles, changes `sdata_i` only while the write strobe is low, and returns both strobes high before raising chip-select.

// File: rtl/lcd_serial_pkg.sv
package lcd_serial_pkg;

  localparam int PFX_W = 3;
  localparam logic [PFX_W-1:0] PFX_READ  = 3'b110;
  localparam logic [PFX_W-1:0] PFX_WRITE = 3'b101;
  localparam logic [PFX_W-1:0] PFX_CMD   = 3'b100;

  typedef enum logic [2:0] {
    ST_PFX,    // collecting the operation prefix
    ST_ADDR,   // collecting the word address
    ST_RD,     // read-only data phase
    ST_WSEL,   // 101 mode, nibble boundary: read or write decides
    ST_RMWRD,  // 101 mode, old nibble going out
    ST_WR,     // 101 mode, new nibble coming in
    ST_CMD,    // configuration words
    ST_DEAD    // unknown prefix, wait for deselect
  } phase_t;

  typedef enum logic [1:0] {
    MD_NONE,
    MD_READ,
    MD_WRITE,
    MD_CMD
  } mode_t;

endpackage

// File: rtl/lcd_serial_sync.sv
module lcd_serial_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= INIT[g];
        stab_q <= INIT[g];
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end

endmodule

// File: rtl/lcd_serial_store.sv
module lcd_serial_store #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic [AW-1:0] saddr_i,
  output logic [DW-1:0] sdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (we_i && waddr_i == AW'(g))
        mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
  assign sdata_o = mem[saddr_i];

endmodule

// File: rtl/lcd_serial_engine.sv
module lcd_serial_engine
  import lcd_serial_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 4,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desel_i,
  input  logic          wr_rise_i,
  input  logic          rd_rise_i,
  input  logic          din_i,
  input  logic [DW-1:0] word_i,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          dout_o,
  output logic          oe_o,
  output logic          cmd_valid_o,
  output logic [CW-1:0] cmd_code_o
);

  localparam int MAXLEN = (CW > AW) ? CW : AW;
  localparam int CNTW   = $clog2(MAXLEN + 1);
  localparam int DBW    = (DW > 1) ? $clog2(DW) : 1;

  phase_t          st;
  mode_t           md;
  logic [CNTW-1:0] cnt;
  logic [CW-1:0]   sh;
  logic [CW-1:0]   sh_nx;
  logic [DW-1:0]   nib;
  logic [DW-1:0]   nib_nx;
  logic [DBW-1:0]  bsel;

  assign sh_nx  = {sh[CW-2:0], din_i};
  assign nib_nx = {din_i, nib[DW-1:1]};
  assign bsel   = cnt[DBW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_PFX;
      md          <= MD_NONE;
      cnt         <= '0;
      sh          <= '0;
      nib         <= '0;
      addr_o      <= '0;
      we_o        <= 1'b0;
      waddr_o     <= '0;
      wdata_o     <= '0;
      dout_o      <= 1'b0;
      oe_o        <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_code_o  <= '0;
    end else begin
      we_o        <= 1'b0;
      cmd_valid_o <= 1'b0;
      if (desel_i) begin
        st   <= ST_PFX;
        md   <= MD_NONE;
        cnt  <= '0;
        sh   <= '0;
        oe_o <= 1'b0;
      end else begin
        if (wr_rise_i) oe_o <= 1'b0;
        unique case (st)
          ST_PFX: if (wr_rise_i) begin
            sh <= sh_nx;
            if (cnt == CNTW'(PFX_W - 1)) begin
              cnt <= '0;
              if (sh_nx[PFX_W-1:0] == PFX_READ) begin
                st <= ST_ADDR;
                md <= MD_READ;
              end else if (sh_nx[PFX_W-1:0] == PFX_WRITE) begin
                st <= ST_ADDR;
                md <= MD_WRITE;
              end else if (sh_nx[PFX_W-1:0] == PFX_CMD) begin
                st <= ST_CMD;
                md <= MD_CMD;
              end else begin
                st <= ST_DEAD;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADDR: if (wr_rise_i) begin
            sh <= sh_nx;
            if (cnt == CNTW'(AW - 1)) begin
              cnt    <= '0;
              addr_o <= sh_nx[AW-1:0];
              st     <= (md == MD_READ) ? ST_RD : ST_WSEL;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_RD: if (rd_rise_i) begin
            dout_o <= word_i[bsel];
            oe_o   <= 1'b1;
            if (cnt == CNTW'(DW - 1)) begin
              cnt    <= '0;
              addr_o <= addr_o + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_WSEL: begin
            if (rd_rise_i) begin
              dout_o <= word_i[0];
              oe_o   <= 1'b1;
              cnt    <= CNTW'(1);
              st     <= ST_RMWRD;
            end else if (wr_rise_i) begin
              nib <= nib_nx;
              cnt <= CNTW'(1);
              st  <= ST_WR;
            end
          end
          ST_RMWRD: if (rd_rise_i) begin
            dout_o <= word_i[bsel];
            if (cnt == CNTW'(DW - 1)) begin
              cnt <= '0;
              st  <= ST_WR;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_WR: if (wr_rise_i) begin
            nib <= nib_nx;
            if (cnt == CNTW'(DW - 1)) begin
              cnt     <= '0;
              we_o    <= 1'b1;
              waddr_o <= addr_o;
              wdata_o <= nib_nx;
              addr_o  <= addr_o + 1'b1;
              st      <= ST_WSEL;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_CMD: if (wr_rise_i) begin
            sh <= sh_nx;
            if (cnt == CNTW'(CW - 1)) begin
              cnt         <= '0;
              cmd_valid_o <= 1'b1;
              cmd_code_o  <= sh_nx;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: the line is only driven in a mode that has a read phase
  a_r8_oe_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> (md == MD_READ || md == MD_WRITE));

  // R7: deselect returns the engine to prefix collection with the line released
  a_r7_desel_resets: assert property (@(posedge clk) disable iff (!rst_n)
    desel_i |=> (st == ST_PFX && !oe_o && !we_o && md == MD_NONE));

  // R3: every store write is accompanied by an address step of one
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> (addr_o == waddr_o + 1'b1));

  // R6: command strobe is never wider than one cycle
  a_r6_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  // R1: an unknown prefix produces no side effects
  a_r1_dead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEAD) |-> (!we_o && !cmd_valid_o && !oe_o));

  // R5: a store write only follows write-strobe activity
  a_r5_we_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> $past(wr_rise_i));

endmodule

// File: rtl/lcd_serial_port.sv
module lcd_serial_port #(
  parameter int AW = 6,
  parameter int DW = 4,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_i,
  input  logic          wr_clk_i,
  input  logic          rd_clk_i,
  input  logic          sdata_i,
  output logic          sdata_o,
  output logic          sdata_oe_o,
  input  logic [AW-1:0] scan_addr_i,
  output logic [DW-1:0] scan_data_o,
  output logic          cmd_valid_o,
  output logic [CW-1:0] cmd_code_o
);

  localparam int NSYNC = 4;

  logic [NSYNC-1:0] pins_s;
  logic cs_s, wr_s, rd_s, dat_s;
  logic wr_q, rd_q;
  logic wr_rise, rd_rise;
  logic [AW-1:0] eng_addr, eng_waddr;
  logic [DW-1:0] eng_word, eng_wdata;
  logic          eng_we;

  lcd_serial_sync #(.W(NSYNC), .INIT('1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({cs_n_i, wr_clk_i, rd_clk_i, sdata_i}),
    .sync_o  (pins_s)
  );

  assign {cs_s, wr_s, rd_s, dat_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_s;
      rd_q <= rd_s;
    end
  end

  assign wr_rise = wr_s & ~wr_q;
  assign rd_rise = rd_s & ~rd_q;

  lcd_serial_engine #(.AW(AW), .DW(DW), .CW(CW)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .desel_i     (cs_s),
    .wr_rise_i   (wr_rise),
    .rd_rise_i   (rd_rise),
    .din_i       (dat_s),
    .word_i      (eng_word),
    .addr_o      (eng_addr),
    .we_o        (eng_we),
    .waddr_o     (eng_waddr),
    .wdata_o     (eng_wdata),
    .dout_o      (sdata_o),
    .oe_o        (sdata_oe_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_code_o  (cmd_code_o)
  );

  lcd_serial_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (eng_we),
    .waddr_i (eng_waddr),
    .wdata_i (eng_wdata),
    .raddr_i (eng_addr),
    .rdata_o (eng_word),
    .saddr_i (scan_addr_i),
    .sdata_o (scan_data_o)
  );

  // R7: while deselected no store write and no command strobe can leave
  a_r7_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> (!eng_we && !cmd_valid_o));

  // R8: a write-strobe rise always releases the line
  a_r8_wr_releases: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise |=> !sdata_oe_o);

endmodule

// File: tb/lcd_serial_port_tb.sv
module lcd_serial_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_c = 1'b1, rd_c = 1'b1, din = 1'b1;
  logic       dout, oe;
  logic [5:0] scan_a = '0;
  logic [3:0] scan_d;
  logic       cvalid;
  logic [8:0] ccode;

  int checks = 0;
  int fails  = 0;
  int cmd_cnt = 0;
  logic [8:0] cmd_log [8];

  always #10 clk = ~clk;

  lcd_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .wr_clk_i(wr_c), .rd_clk_i(rd_c),
    .sdata_i(din), .sdata_o(dout), .sdata_oe_o(oe), .scan_addr_i(scan_a),
    .scan_data_o(scan_d), .cmd_valid_o(cvalid), .cmd_code_o(ccode)
  );

  always @(posedge clk) begin
    if (rst_n && cvalid) begin
      if (cmd_cnt < 8) cmd_log[cmd_cnt] <= ccode;
      cmd_cnt <= cmd_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 1'b0; wait_cyc(6);
  endtask

  task automatic desel();
    wr_c = 1'b1; rd_c = 1'b1; wait_cyc(2);
    cs_n = 1'b1; wait_cyc(10);
  endtask

  task automatic wr_bit(input logic b);
    wr_c = 1'b0; din = b; wait_cyc(6);
    wr_c = 1'b1; wait_cyc(6);
  endtask

  task automatic rd_bit(output logic b);
    rd_c = 1'b0; wait_cyc(6);
    rd_c = 1'b1; wait_cyc(6);
    b = dout;
  endtask

  task automatic send_msb(input logic [8:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) wr_bit(v[i]);
  endtask

  task automatic send_nib(input logic [3:0] v);
    for (int i = 0; i < 4; i++) wr_bit(v[i]);
  endtask

  task automatic get_nib(output logic [3:0] v);
    for (int i = 0; i < 4; i++) begin
      logic b;
      rd_bit(b);
      v[i] = b;
    end
  endtask

  task automatic scan_chk(input string tag, input logic [5:0] a, input logic [3:0] exp);
    scan_a = a; wait_cyc(1);
    chk(tag, 16'(scan_d), 16'(exp));
  endtask

  task automatic t_reset();
    chk("R9 oe after reset", 16'(oe), 16'h0);
    chk("R9 cmd strobe after reset", 16'(cvalid), 16'h0);
    scan_chk("R9 word 0 after reset", 6'd0, 4'h0);
    scan_chk("R9 word 63 after reset", 6'd63, 4'h0);
  endtask

  task automatic t_write();
    sel(); send_msb(9'b101, 3); send_msb(9'd5, 6); send_nib(4'hA);
    chk("R8 oe low in write", 16'(oe), 16'h0);
    desel();
    scan_chk("R2 write word 5", 6'd5, 4'hA);
  endtask

  task automatic t_wrap_write();
    sel(); send_msb(9'b101, 3); send_msb(9'd62, 6);
    send_nib(4'h1); send_nib(4'h2); send_nib(4'h3);
    desel();
    scan_chk("R3 word 62", 6'd62, 4'h1);
    scan_chk("R3 word 63", 6'd63, 4'h2);
    scan_chk("R3 wrap to word 0", 6'd0, 4'h3);
  endtask

  task automatic t_read();
    logic [3:0] v;
    sel(); send_msb(9'b110, 3); send_msb(9'd62, 6);
    chk("R8 oe low before read strobe", 16'(oe), 16'h0);
    get_nib(v); chk("R4 read word 62", 16'(v), 16'h1);
    chk("R8 oe high in read", 16'(oe), 16'h1);
    get_nib(v); chk("R4 read word 63", 16'(v), 16'h2);
    get_nib(v); chk("R3 read wraps to word 0", 16'(v), 16'h3);
    desel();
    chk("R8 oe low after deselect", 16'(oe), 16'h0);
  endtask

  task automatic t_rmw();
    logic [3:0] v;
    sel(); send_msb(9'b101, 3); send_msb(9'd5, 6);
    get_nib(v); chk("R5 old nibble out", 16'(v), 16'hA);
    send_nib(4'h6);
    chk("R8 oe released by write strobe", 16'(oe), 16'h0);
    send_nib(4'h9);
    desel();
    scan_chk("R5 new nibble same word", 6'd5, 4'h6);
    scan_chk("R5 address advanced after rmw", 6'd6, 4'h9);
  endtask

  task automatic t_cmd();
    int c0;
    c0 = cmd_cnt;
    sel(); send_msb(9'b100, 3); send_msb(9'h1A5, 9);
    chk("R8 oe low in command", 16'(oe), 16'h0);
    send_msb(9'h0FF, 9);
    desel();
    chk("R6 one pulse per code", 16'(cmd_cnt - c0), 16'd2);
    chk("R6 first code", 16'(cmd_log[c0]), 16'h1A5);
    chk("R6 chained code", 16'(cmd_log[c0 + 1]), 16'h0FF);
  endtask

  task automatic t_abort();
    int c0;
    sel(); send_msb(9'b101, 3); send_msb(9'd12, 6); wr_bit(1'b1); wr_bit(1'b1);
    desel();
    scan_chk("R7 partial nibble dropped", 6'd12, 4'h0);
    c0 = cmd_cnt;
    sel(); send_msb(9'b100, 3); send_msb(9'h003, 9); desel();
    sel(); send_msb(9'b101, 3); send_msb(9'd20, 6); send_nib(4'h7); desel();
    chk("R7 mode forgotten, no command", 16'(cmd_cnt - c0), 16'd1);
    scan_chk("R7 new prefix honoured", 6'd20, 4'h7);
  endtask

  task automatic t_bad_prefix();
    int c0;
    c0 = cmd_cnt;
    sel(); send_msb(9'b111, 3); send_msb(9'd10, 6); send_nib(4'hF);
    send_msb(9'h155, 9);
    desel();
    scan_chk("R1 unknown prefix no write", 6'd10, 4'h0);
    chk("R1 unknown prefix no command", 16'(cmd_cnt - c0), 16'd0);
    sel(); send_msb(9'b011, 3); send_msb(9'd10, 6); send_nib(4'hF); desel();
    scan_chk("R1 prefix 011 ignored", 6'd10, 4'h0);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_write();
    t_wrap_write();
    t_read();
    t_rmw();
    t_cmd();
    t_abort();
    t_bad_prefix();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule